// File: doc/BRIEF.md
# Write-Protected Seconds Real-Time Clock

This block keeps a 32-bit count of elapsed seconds. A prescaler counts clock cycles up to a parameterised clock frequency and issues a one-cycle tick, and each tick advances the seconds counter by one. Software sees the counter through a 16-bit register window with a simple strobe interface. The window has three registers: the upper half of the counter, the lower half of the counter, and a key register that arms or disarms loading.

Loading is protected by a small two-state guard machine. In state `WE_LOCKED`, writes to either half are dropped. A key write with bit 0 set moves the machine to `WE_ARMED`, and a key write with bit 0 clear returns it to `WE_LOCKED`. While the machine is in `WE_ARMED`, a lower-half write loads bits 15:0 and leaves the machine armed. An upper-half write loads bits 31:16 and sends the machine back to `WE_LOCKED`. Software therefore arms the guard, writes the lower half and then writes the upper half. A lower-half load also restarts the prescaler, so the first second after the load is a full second.

Any access at an offset other than the three registers reads as zero and changes nothing. Such an access raises an error flag for one cycle.

Top module: `secs_rtc`

## Requirements
- R1: On reset the counter holds INIT_SECS, the guard is in `WE_LOCKED`, the prescaler is zero and `bad_access` is 0.
- R2: Without software loads, the counter increases by one at the end of every CLK_HZ clock cycles. The first increment after reset comes on the CLK_HZ-th rising edge.
- R3: A read (`req_valid`=1, `req_write`=0) returns on `rd_data` in the same cycle: bits 31:16 of the counter at offset 0x0, bits 15:0 at offset 0x4, and zero at offset 0x8. `rd_data` is zero whenever no read is presented.
- R4: A write at offset 0x8 puts the guard in `WE_ARMED` if wdata bit 0 is 1, and in `WE_LOCKED` if it is 0.
- R5: In `WE_ARMED`, a write at offset 0x4 replaces counter bits 15:0, leaves bits 31:16 unchanged, and keeps the guard armed.
- R6: In `WE_ARMED`, a write at offset 0x0 replaces counter bits 31:16 and returns the guard to `WE_LOCKED`.
- R7: In `WE_LOCKED`, writes at offset 0x0 or 0x4 leave the counter unchanged.
- R8: An access at any offset other than 0x0, 0x4 or 0x8 reads as zero and is ignored on write. It sets `bad_access` to 1 for exactly the cycle after the access edge.
- R9: A lower-half load restarts the prescaler, so the next increment comes CLK_HZ edges after the load edge.
- R10: If a lower-half load coincides with a tick, the low half takes the written value and the upper half is unchanged (the tick is dropped). If an upper-half load coincides with a tick, the upper half takes the written value and the low half increments modulo 2^16 without carry.
- R11: The counter wraps from 0xFFFFFFFF to 0x00000000 on a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the window |
| req_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data, same cycle as the read strobe |
| bad_access | output | 1 | One-cycle pulse after an access to an undefined offset |

## Verification
The hardest cases to reach are the coincidences in R10: a software load on exactly the edge where the prescaler issues its tick. The bench runs the block with an 8-cycle second and counts rising edges from reset. Because a lower-half load restarts the prescaler at a known edge, the bench can place the following lower-half or upper-half write exactly eight edges later, on the tick, with 0xFFFF in the low half to show whether a carry escaped. Beyond that, the bench sweeps every undefined offset with the guard armed and checks the counter against a value computed from the edge count.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    typedef enum logic [1:0] {
        SEL_HI   = 2'd0,
        SEL_LO   = 2'd1,
        SEL_KEY  = 2'd2,
        SEL_NONE = 2'd3
    } rtc_sel_e;

    typedef enum logic {
        WE_LOCKED = 1'b0,
        WE_ARMED  = 1'b1
    } rtc_we_e;
endpackage

// File: rtl/rtc_decode.sv
module rtc_decode
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output rtc_sel_e          sel
);
    localparam logic [ADDR_W-1:0] OFF_HI  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_LO  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFF_KEY = ADDR_W'(8);

    always_comb begin
        if (addr == OFF_HI)       sel = SEL_HI;
        else if (addr == OFF_LO)  sel = SEL_LO;
        else if (addr == OFF_KEY) sel = SEL_KEY;
        else                      sel = SEL_NONE;
    end
endmodule

// File: rtl/rtc_wr_guard.sv
module rtc_wr_guard
    import rtc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr,
    input  rtc_sel_e sel,
    input  logic     key_bit,
    output logic     lo_load,
    output logic     hi_load
);
    rtc_we_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WE_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        lo_load = 1'b0;
        hi_load = 1'b0;
        unique case (state_q)
            WE_LOCKED: begin
                if (wr && sel == SEL_KEY && key_bit) state_d = WE_ARMED;
            end
            WE_ARMED: begin
                if (wr && sel == SEL_KEY && !key_bit) state_d = WE_LOCKED;
                if (wr && sel == SEL_LO) lo_load = 1'b1;
                if (wr && sel == SEL_HI) begin
                    hi_load = 1'b1;
                    state_d = WE_LOCKED;
                end
            end
            default: state_d = WE_LOCKED;
        endcase
    end

    // R6: an upper-half load disarms the guard
    a_r6_hi_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        hi_load |=> state_q == WE_LOCKED);
    // R5: a lower-half load leaves the guard armed
    a_r5_lo_keeps_armed: assert property (@(posedge clk) disable iff (!rst_n)
        lo_load |=> state_q == WE_ARMED);
    // R7: no load while locked
    a_r7_locked_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WE_LOCKED) |-> !(lo_load || hi_load));
endmodule

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
    parameter int CLK_HZ = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PRE_W = (CLK_HZ > 2) ? $clog2(CLK_HZ) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(CLK_HZ - 1);

    logic [PRE_W-1:0] pre_q;

    assign tick = (pre_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)       pre_q <= '0;
        else if (restart) pre_q <= '0;
        else if (tick)    pre_q <= '0;
        else              pre_q <= pre_q + 1'b1;
    end

    // R9: a restart zeroes the prescaler
    a_r9_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> pre_q == '0);
    // R2: the prescaler never passes its terminal count
    a_r2_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= LAST);
endmodule

// File: rtl/rtc_sec_count.sv
module rtc_sec_count #(
    parameter int          HALF_W    = 16,
    parameter logic [31:0] INIT_SECS = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              lo_load,
    input  logic              hi_load,
    input  logic [HALF_W-1:0] wdata,
    output logic [2*HALF_W-1:0] cnt
);
    localparam int CNT_W = 2 * HALF_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CNT_W'(INIT_SECS);
        end else if (lo_load) begin
            cnt[HALF_W-1:0] <= wdata;
        end else if (hi_load) begin
            cnt[CNT_W-1:HALF_W] <= wdata;
            if (tick) cnt[HALF_W-1:0] <= cnt[HALF_W-1:0] + 1'b1;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R7: with no load and no tick, the count holds
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_load && !hi_load && !tick) |=> $stable(cnt));
    // R2: a lone tick adds one
    a_r2_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !lo_load && !hi_load) |=> cnt == $past(cnt) + 1'b1);
    // R10: a lower-half load keeps the upper half even on a tick
    a_r10_lo_priority: assert property (@(posedge clk) disable iff (!rst_n)
        lo_load |=> cnt[CNT_W-1:HALF_W] == $past(cnt[CNT_W-1:HALF_W]));
    // R11: wrap to zero
    a_r11_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !lo_load && !hi_load && cnt == '1) |=> cnt == '0);
endmodule

// File: rtl/secs_rtc.sv
module secs_rtc
    import rtc_pkg::*;
#(
    parameter int          CLK_HZ    = 100_000_000,
    parameter logic [31:0] INIT_SECS = 32'h0,
    parameter int          ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    output logic [15:0]       rd_data,
    output logic              bad_access
);
    localparam int HALF_W = 16;

    rtc_sel_e            sel;
    logic                wr, rd, lo_load, hi_load, tick;
    logic [2*HALF_W-1:0] cnt;

    assign wr = req_valid && req_write;
    assign rd = req_valid && !req_write;

    rtc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (req_addr),
        .sel  (sel)
    );

    rtc_wr_guard u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr),
        .sel     (sel),
        .key_bit (req_wdata[0]),
        .lo_load (lo_load),
        .hi_load (hi_load)
    );

    rtc_prescale #(.CLK_HZ(CLK_HZ)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (lo_load),
        .tick    (tick)
    );

    rtc_sec_count #(.HALF_W(HALF_W), .INIT_SECS(INIT_SECS)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .lo_load (lo_load),
        .hi_load (hi_load),
        .wdata   (req_wdata),
        .cnt     (cnt)
    );

    always_comb begin
        rd_data = '0;
        if (rd) begin
            unique case (sel)
                SEL_HI:   rd_data = cnt[2*HALF_W-1:HALF_W];
                SEL_LO:   rd_data = cnt[HALF_W-1:0];
                SEL_KEY:  rd_data = '0;
                SEL_NONE: rd_data = '0;
                default:  rd_data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bad_access <= 1'b0;
        else        bad_access <= req_valid && (sel == SEL_NONE);
    end

    // R8: the error pulse only follows an access
    a_r8_bad_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |-> $past(req_valid));
    // R8: an undefined offset never loads the counter
    a_r8_no_load_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> !(lo_load || hi_load));
    // R3: idle bus reads as zero
    a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> rd_data == 16'h0);
endmodule

// File: tb/test_secs_rtc.sv
module test_secs_rtc;
    localparam int HZ = 8;
    localparam logic [31:0] INIT = 32'h0001_FFFE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] rd_data;
    logic        bad_access;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    secs_rtc #(.CLK_HZ(HZ), .INIT_SECS(INIT), .ADDR_W(8)) i_secs_rtc (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .bad_access(bad_access)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at cycle %0d: got %h expected %h", req, cyc, act, exp);
        end
    endtask

    // write: driven at a falling edge, taken at the next rising edge
    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    // read: combinational, consumes no edge
    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        #1 d = rd_data;
        req_valid = 1'b0;
        #1;
    endtask

    task automatic chk_cnt(input string req, input logic [31:0] exp);
        logic [15:0] h, l;
        rd(8'h00, h);
        rd(8'h04, l);
        chk(req, {h, l}, exp);
    endtask

    task automatic wait_to(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        int e;
        repeat (3) @(negedge clk);
        chk("R1 bad_access in reset", 32'(bad_access), 32'h0);
        rst_n = 1'b1;
        // cyc is 0 here; first tick on edge 8
        chk_cnt("R1 reset count", INIT);
        rd(8'h08, d); chk("R3 key reads zero", 32'(d), 32'h0);
        chk("R3 idle rd_data zero", 32'(rd_data), 32'h0);

        // R7: locked writes dropped
        wr(8'h00, 16'h1234);
        wr(8'h04, 16'h5678);
        chk_cnt("R7 locked writes ignored", INIT);
        // R4: key with bit0=0 keeps it locked
        wr(8'h08, 16'hFFFE);
        wr(8'h04, 16'h4321);
        chk_cnt("R4 key bit0=0 stays locked", INIT);
        chk("R8 valid access no pulse", 32'(bad_access), 32'h0);

        // R2 / carry
        wait_to(7);  chk_cnt("R2 before first tick", INIT);
        wait_to(8);  chk_cnt("R2 first tick", INIT + 1);
        wait_to(15); chk_cnt("R2 before second tick", INIT + 1);
        wait_to(16); chk_cnt("R2 carry into upper half", 32'h0002_0000);

        // R4/R5/R6/R9: load sequence
        wr(8'h08, 16'h0001);
        wr(8'h04, 16'h0010); e = cyc;
        wr(8'h00, 16'h00AB);
        chk_cnt("R6 upper half loaded", 32'h00AB_0010);
        wr(8'h00, 16'h5555);
        wr(8'h04, 16'h7777);
        chk_cnt("R6 upper write disarmed guard", 32'h00AB_0010);
        wait_to(e + 7); chk_cnt("R9 no tick before full second", 32'h00AB_0010);
        wait_to(e + 8); chk_cnt("R9 tick one second after load", 32'h00AB_0011);

        // R5: two lower writes both take effect
        wr(8'h08, 16'h0001);
        wr(8'h04, 16'h0100);
        chk_cnt("R5 lower half loaded, upper kept", 32'h00AB_0100);
        wr(8'h04, 16'h0200);
        chk_cnt("R5 guard still armed after lower write", 32'h00AB_0200);
        wr(8'h00, 16'h0003);
        chk_cnt("R6 upper after two lowers", 32'h0003_0200);

        // R10: lower load on a tick edge
        wr(8'h08, 16'h0001);
        wr(8'h04, 16'hFFFF); e = cyc;
        wait_to(e + 7);
        wr(8'h04, 16'h0040); e = cyc;
        chk_cnt("R10 lower load wins over tick, no carry", 32'h0003_0040);
        wait_to(e + 7); chk_cnt("R10 restart after coincident load", 32'h0003_0040);
        wait_to(e + 8); chk_cnt("R10 tick after coincident load", 32'h0003_0041);

        // R10: upper load on a tick edge
        wr(8'h04, 16'hFFFF); e = cyc;
        wait_to(e + 7);
        wr(8'h00, 16'h0777);
        chk_cnt("R10 upper load with tick, low wraps without carry", 32'h0777_0000);

        // R11: wrap
        wr(8'h08, 16'h0001);
        wr(8'h04, 16'hFFFF); e = cyc;
        wr(8'h00, 16'hFFFF);
        wait_to(e + 7); chk_cnt("R11 all ones before tick", 32'hFFFF_FFFF);
        wait_to(e + 8); chk_cnt("R11 wrap to zero", 32'h0);

        // R8: sweep of undefined offsets with guard armed
        wr(8'h08, 16'h0001);
        for (int a = 1; a < 256; a++) begin
            if (a == 4 || a == 8) continue;
            wr(8'(a), 16'(a * 16'h0101));
            chk("R8 pulse after bad write", 32'(bad_access), 32'h1);
            rd(8'(a), d);
            chk("R8 bad offset reads zero", 32'(d), 32'h0);
            @(negedge clk);
            chk("R8 pulse lasts one cycle", 32'(bad_access), 32'h0);
        end
        chk_cnt("R8 sweep left counter untouched", 32'((cyc - e) / HZ - 1));
        // guard still armed after the sweep
        wr(8'h04, 16'h0ABC);
        chk_cnt("R8 guard state untouched by sweep", 32'h0000_0ABC);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule